// File: doc/BRIEF.md
# Supervised Mode Controller with Flash Entry

This block is the operating-mode sequencer of a system-supervision device. It receives already-decoded 3-bit mode-register writes from the serial interface. Each write comes with a flag that says whether it arrived inside the legal watchdog window. The block also monitors an oscillator-fail level, a wake-up event, a watchdog-overflow strobe and a 1 ms tick. It drives the current operating mode, a one-cycle system-reset pulse and an encoded reason for the latest reset.

The block has four modes. Normal is the running state. Start-up is the initialisation phase that follows every reset, and it is bounded in time. Flash is the reprogramming state. Fail-safe is entered when the clock reference is lost. Flash is reached in three steps. Software first writes a three-code arming pattern in Normal, which forces a reset into Start-up. Software then answers within the start-up time with the init-Flash code. That answer is accepted once for each arming.

Every input is sampled on the rising clock edge. Each output is a register, so it reflects a stimulus one cycle later.

Top module: `mc_supervisor`

## Requirements
- R1: After reset, the mode is Start-up (mode code 1), the reset pulse is low, the reset source is 0 (power-on), and Flash is not armed. Mode codes are: 0 Normal, 1 Start-up, 2 Flash, 3 Fail-safe.
- R2: In Normal, three consecutive in-window writes of 3'b111, 3'b001 and 3'b111 arm Flash. On the next cycle the mode is Start-up, the reset pulse is high for that cycle, and the reset source is 1.
- R3: In Normal, a write that breaks the arming pattern returns the tracker to idle, so the pattern must restart from its first code. A write breaks the pattern if it has the wrong code for the current step or arrives outside the window.
- R4: In Start-up with Flash armed, an in-window write of 3'b011 enters Flash without a reset pulse. This consumes the arming, so a second 3'b011 after any later return to Start-up is illegal.
- R5: In Start-up, the following writes are illegal: 3'b011 without arming, any write outside the window, and any code other than 3'b011 or 3'b101. An illegal write pulses reset, re-enters Start-up and sets reset source 4.
- R6: In Start-up, an in-window write of 3'b101 enters Normal without a reset pulse and clears any armed Flash entry.
- R7: When STARTUP_MS tick pulses arrive in Start-up with no write, the block pulses reset, re-enters Start-up with its tick count cleared, and sets reset source 5.
- R8: In Flash, a write of 3'b111 keeps Flash, whatever the window flag. Any other code pulses reset, enters Start-up and sets reset source 2.
- R9: A watchdog overflow in Normal or Flash pulses reset, enters Start-up and sets reset source 3. A watchdog overflow is ignored in Start-up and in Fail-safe.
- R10: While the oscillator-fail input is high, the next mode is Fail-safe from any mode, with no reset pulse. This input overrides every other input, and it clears both the arming and the tracker.
- R11: The block leaves Fail-safe only when a wake event arrives while the oscillator is good. It then pulses reset, enters Start-up and sets reset source 6.
- R12: The reset source changes only in a cycle in which the reset pulse is high; otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Decoded mode-register write strobe |
| wr_code_i | input | 3 | Mode code of the write |
| wr_in_win_i | input | 1 | Write fell inside the legal watchdog window |
| tick_1ms_i | input | 1 | 1 ms timebase pulse |
| osc_fail_i | input | 1 | Oscillator failure level |
| wake_i | input | 1 | Wake-up event |
| wdg_ovf_i | input | 1 | Watchdog overflow strobe |
| mode_o | output | 2 | Current mode code |
| sys_rst_o | output | 1 | System reset pulse, one cycle per reset event |
| rst_src_o | output | 3 | Cause of the latest reset |

## Verification
Every result is due exactly one clock edge after the inputs that cause it. Mode, reset pulse and reset source all come from registers. The bench drives inputs on the falling edge and clears them one falling edge later, then checks the outputs at that second falling edge, when the rising edge in between has applied the stimulus. A behavioural reference model steps on the same rising edge and is compared at every falling edge. The compare therefore also confirms that each reset pulse lasts one cycle and that the timeout fires on the STARTUP_MS-th tick and not before.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'd0,
    MODE_STARTUP  = 2'd1,
    MODE_FLASH    = 2'd2,
    MODE_FAILSAFE = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    SRC_POWER   = 3'd0,
    SRC_ARM     = 3'd1,
    SRC_FLEXIT  = 3'd2,
    SRC_WDG     = 3'd3,
    SRC_ILLEGAL = 3'd4,
    SRC_TIMEOUT = 3'd5,
    SRC_WAKE    = 3'd6
  } src_e;

  localparam logic [2:0] CODE_SERVE    = 3'b111;
  localparam logic [2:0] CODE_ARM_MID  = 3'b001;
  localparam logic [2:0] CODE_GO_FLASH = 3'b011;
  localparam logic [2:0] CODE_GO_NORM  = 3'b101;

  localparam int unsigned ARM_STEPS = 3;

  function automatic logic [2:0] arm_code(input int unsigned step);
    return (step == 1) ? CODE_ARM_MID : CODE_SERVE;
  endfunction
endpackage

// File: rtl/mc_arm_tracker.sv
module mc_arm_tracker
  import mc_pkg::*;
#(
  parameter int unsigned STEPS = ARM_STEPS
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       wr_valid_i,
  input  logic [2:0] wr_code_i,
  input  logic       wr_in_win_i,
  output logic       done_o
);
  localparam int unsigned SW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [SW-1:0]    step_q;
  logic [STEPS-1:0] step_hit;
  logic             hit;

  for (genvar g = 0; g < STEPS; g++) begin : g_cmp
    assign step_hit[g] = (wr_code_i == arm_code(g));
  end

  assign hit    = wr_valid_i && wr_in_win_i && step_hit[step_q];
  assign done_o = en_i && hit && (step_q == SW'(STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
    end else if (!en_i) begin
      step_q <= '0;
    end else if (wr_valid_i) begin
      if (hit && step_q != SW'(STEPS - 1)) step_q <= step_q + 1'b1;
      else                                 step_q <= '0;
    end
  end
endmodule

// File: rtl/mc_startup_timer.sv
module mc_startup_timer #(
  parameter int unsigned LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i || !run_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mc_mode_fsm.sv
module mc_mode_fsm
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [2:0] wr_code_i,
  input  logic       wr_in_win_i,
  input  logic       osc_fail_i,
  input  logic       wake_i,
  input  logic       wdg_ovf_i,
  input  logic       arm_done_i,
  input  logic       su_expire_i,
  output mode_e      mode_o,
  output logic       sys_rst_o,
  output src_e       rst_src_o,
  output logic       restart_o
);
  mode_e mode_q, mode_d;
  src_e  src_q, src_d, go_src;
  logic  armed_q, armed_d;
  logic  rst_q, go_su;

  always_comb begin
    mode_d  = mode_q;
    armed_d = armed_q;
    go_su   = 1'b0;
    go_src  = src_q;
    if (osc_fail_i) begin
      mode_d  = MODE_FAILSAFE;
      armed_d = 1'b0;
    end else begin
      unique case (mode_q)
        MODE_FAILSAFE: begin
          if (wake_i) begin go_su = 1'b1; go_src = SRC_WAKE; end
        end
        MODE_NORMAL: begin
          if (wdg_ovf_i)       begin go_su = 1'b1; go_src = SRC_WDG; end
          else if (arm_done_i) begin go_su = 1'b1; go_src = SRC_ARM; end
        end
        MODE_STARTUP: begin
          if (wr_valid_i) begin
            if (wr_in_win_i && wr_code_i == CODE_GO_FLASH && armed_q) begin
              mode_d  = MODE_FLASH;
              armed_d = 1'b0;
            end else if (wr_in_win_i && wr_code_i == CODE_GO_NORM) begin
              mode_d  = MODE_NORMAL;
              armed_d = 1'b0;
            end else begin
              go_su  = 1'b1;
              go_src = SRC_ILLEGAL;
            end
          end else if (su_expire_i) begin
            go_su  = 1'b1;
            go_src = SRC_TIMEOUT;
          end
        end
        MODE_FLASH: begin
          if (wdg_ovf_i) begin
            go_su = 1'b1; go_src = SRC_WDG;
          end else if (wr_valid_i && wr_code_i != CODE_SERVE) begin
            go_su = 1'b1; go_src = SRC_FLEXIT;
          end
        end
        default: ;
      endcase
      if (go_su) begin
        mode_d  = MODE_STARTUP;
        armed_d = (go_src == SRC_ARM);
      end
    end
    src_d = go_su ? go_src : src_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_STARTUP;
      src_q   <= SRC_POWER;
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      src_q   <= src_d;
      armed_q <= armed_d;
      rst_q   <= go_su;
    end
  end

  assign mode_o    = mode_q;
  assign rst_src_o = src_q;
  assign sys_rst_o = rst_q;
  assign restart_o = go_su;
endmodule

// File: rtl/mc_supervisor.sv
module mc_supervisor
  import mc_pkg::*;
#(
  parameter int unsigned STARTUP_MS = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_valid_i,
  input  logic [2:0] wr_code_i,
  input  logic       wr_in_win_i,
  input  logic       tick_1ms_i,
  input  logic       osc_fail_i,
  input  logic       wake_i,
  input  logic       wdg_ovf_i,
  output logic [1:0] mode_o,
  output logic       sys_rst_o,
  output logic [2:0] rst_src_o
);
  mode_e mode;
  src_e  src;
  logic  arm_done, su_expire, restart;

  mc_arm_tracker #(.STEPS(ARM_STEPS)) u_arm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (mode == MODE_NORMAL),
    .wr_valid_i (wr_valid_i),
    .wr_code_i  (wr_code_i),
    .wr_in_win_i(wr_in_win_i),
    .done_o     (arm_done)
  );

  mc_startup_timer #(.LIMIT(STARTUP_MS)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (mode == MODE_STARTUP),
    .restart_i(restart),
    .tick_i   (tick_1ms_i),
    .expire_o (su_expire)
  );

  mc_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_code_i  (wr_code_i),
    .wr_in_win_i(wr_in_win_i),
    .osc_fail_i (osc_fail_i),
    .wake_i     (wake_i),
    .wdg_ovf_i  (wdg_ovf_i),
    .arm_done_i (arm_done),
    .su_expire_i(su_expire),
    .mode_o     (mode),
    .sys_rst_o  (sys_rst_o),
    .rst_src_o  (src),
    .restart_o  (restart)
  );

  assign mode_o    = mode;
  assign rst_src_o = src;
endmodule

// File: rtl/mc_supervisor_chk.sv
module mc_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_valid_i,
  input logic [2:0] wr_code_i,
  input logic       osc_fail_i,
  input logic       wake_i,
  input logic       wdg_ovf_i,
  input logic [1:0] mode_o,
  input logic       sys_rst_o,
  input logic [2:0] rst_src_o
);
  a_r10_osc_to_failsafe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_fail_i |=> (mode_o == 2'd3 && !sys_rst_o));

  a_r4_flash_only_from_startup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> ($past(mode_o) == 2'd1 && !sys_rst_o));

  a_r8_flash_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && wr_valid_i && wr_code_i != 3'b111 && !osc_fail_i && !wdg_ovf_i)
    |=> (mode_o == 2'd1 && sys_rst_o && rst_src_o == 3'd2));

  a_r9_wdg_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_o == 2'd0 || mode_o == 2'd2) && wdg_ovf_i && !osc_fail_i)
    |=> (mode_o == 2'd1 && sys_rst_o && rst_src_o == 3'd3));

  a_r11_failsafe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd3 && (osc_fail_i || !wake_i)) |=> (mode_o == 2'd3));

  a_r12_src_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sys_rst_o |-> $stable(rst_src_o));

  a_r2_reset_lands_in_startup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (mode_o == 2'd1));
endmodule

bind mc_supervisor mc_supervisor_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_valid_i(wr_valid_i),
  .wr_code_i (wr_code_i),
  .osc_fail_i(osc_fail_i),
  .wake_i    (wake_i),
  .wdg_ovf_i (wdg_ovf_i),
  .mode_o    (mode_o),
  .sys_rst_o (sys_rst_o),
  .rst_src_o (rst_src_o)
);

// File: tb/sim_mc_supervisor.sv
module sim_mc_supervisor;
  localparam int SU_MS = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic [2:0] wr_code = 3'd0;
  logic       wr_win = 1'b0;
  logic       tick = 1'b0, osc = 1'b0, wake = 1'b0, ovf = 1'b0;
  logic [1:0] mode;
  logic       srst;
  logic [2:0] src;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model state
  int m_mode = 1, m_src = 0, m_rst = 0, m_armed = 0, m_stage = 0, m_cnt = 0;

  always #5 clk = ~clk;

  mc_supervisor #(.STARTUP_MS(SU_MS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_code_i(wr_code),
    .wr_in_win_i(wr_win), .tick_1ms_i(tick), .osc_fail_i(osc), .wake_i(wake),
    .wdg_ovf_i(ovf), .mode_o(mode), .sys_rst_o(srst), .rst_src_o(src)
  );

  task automatic model_step();
    int pattern[3] = '{7, 1, 7};
    int nmode = m_mode, nsrc = m_src;
    bit fire = 0;
    if (osc) begin
      nmode = 3; m_armed = 0;
    end else if (m_mode == 3) begin
      if (wake) begin fire = 1; nsrc = 6; end
    end else if (m_mode == 0) begin
      if (ovf) begin fire = 1; nsrc = 3; end
      else if (wr_valid) begin
        if (wr_win && int'(wr_code) == pattern[m_stage]) begin
          if (m_stage == 2) begin fire = 1; nsrc = 1; end
          else m_stage++;
        end else m_stage = 0;
      end
    end else if (m_mode == 1) begin
      if (wr_valid) begin
        if (wr_win && wr_code == 3'b011 && m_armed == 1) begin nmode = 2; m_armed = 0; end
        else if (wr_win && wr_code == 3'b101) begin nmode = 0; m_armed = 0; end
        else begin fire = 1; nsrc = 4; end
      end else if (tick) begin
        m_cnt++;
        if (m_cnt == SU_MS) begin fire = 1; nsrc = 5; end
      end
    end else begin
      if (ovf) begin fire = 1; nsrc = 3; end
      else if (wr_valid && wr_code != 3'b111) begin fire = 1; nsrc = 2; end
    end
    if (fire) begin
      nmode = 1; m_cnt = 0;
      m_armed = (nsrc == 1) ? 1 : 0;
    end
    if (nmode != 0 || m_mode != 0) m_stage = (nmode == 0 && m_mode == 0) ? m_stage : 0;
    if (nmode != 1) m_cnt = 0;
    m_mode = nmode; m_src = nsrc; m_rst = fire;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 1; m_src = 0; m_rst = 0; m_armed = 0; m_stage = 0; m_cnt = 0;
    end else model_step();
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (int'(mode) != m_mode || int'(srst) != m_rst || int'(src) != m_src) begin
        fails++;
        $display("FAIL model %s actual mode=%0d rst=%0d src=%0d expected mode=%0d rst=%0d src=%0d",
                 cur_req, mode, srst, src, m_mode, m_rst, m_src);
      end
    end
  end

  task automatic chk(input string req, input int em, input int er, input int es);
    checks++;
    if (int'(mode) != em || int'(srst) != er || int'(src) != es) begin
      fails++;
      $display("FAIL %s actual mode=%0d rst=%0d src=%0d expected mode=%0d rst=%0d src=%0d",
               req, mode, srst, src, em, er, es);
    end
  endtask

  task automatic wr(input logic [2:0] c, input logic w);
    @(negedge clk); wr_valid = 1'b1; wr_code = c; wr_win = w;
    @(negedge clk); wr_valid = 1'b0; wr_win = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
  endtask

  task automatic pulse_ovf();
    @(negedge clk); ovf = 1'b1; @(negedge clk); ovf = 1'b0;
  endtask

  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
  endtask

  task automatic arm();
    wr(3'b111, 1'b1); wr(3'b001, 1'b1); wr(3'b111, 1'b1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog ALL actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cur_req = "R1"; chk("R1", 1, 0, 0);

    cur_req = "R6"; wr(3'b101, 1'b1); chk("R6", 0, 0, 0);

    cur_req = "R3";
    wr(3'b111, 1'b1); wr(3'b001, 1'b1); wr(3'b101, 1'b1);
    wr(3'b001, 1'b1); wr(3'b111, 1'b1); wr(3'b001, 1'b1);
    wr(3'b111, 1'b0);
    chk("R3", 0, 0, 0);
    wr(3'b111, 1'b1); chk("R3", 0, 0, 0);

    cur_req = "R2";
    wr(3'b001, 1'b1); wr(3'b111, 1'b1); chk("R2", 1, 1, 1);
    @(negedge clk); chk("R2", 1, 0, 1);

    cur_req = "R4"; wr(3'b011, 1'b1); chk("R4", 2, 0, 1);
    cur_req = "R8"; wr(3'b111, 1'b0); chk("R12", 2, 0, 1);
    wr(3'b010, 1'b1); chk("R8", 1, 1, 2);

    cur_req = "R5"; wr(3'b011, 1'b1); chk("R5", 1, 1, 4);

    cur_req = "R7";
    for (int i = 0; i < SU_MS - 1; i++) pulse_tick();
    chk("R7", 1, 0, 4);
    pulse_tick(); chk("R7", 1, 1, 5);

    cur_req = "R9"; pulse_ovf(); chk("R9", 1, 0, 5);

    cur_req = "R6";
    wr(3'b101, 1'b1); arm(); chk("R2", 1, 1, 1);
    wr(3'b101, 1'b1); chk("R6", 0, 0, 1);
    pulse_ovf(); chk("R9", 1, 1, 3);
    wr(3'b011, 1'b1); chk("R6", 1, 1, 4);

    cur_req = "R4";
    wr(3'b101, 1'b1); arm(); wr(3'b011, 1'b1); chk("R4", 2, 0, 1);
    pulse_ovf(); chk("R9", 1, 1, 3);
    wr(3'b011, 1'b1); chk("R4", 1, 1, 4);

    cur_req = "R5";
    wr(3'b101, 1'b1); arm(); wr(3'b011, 1'b0); chk("R5", 1, 1, 4);
    wr(3'b110, 1'b1); chk("R5", 1, 1, 4);

    cur_req = "R10";
    wr(3'b101, 1'b1);
    @(negedge clk); osc = 1'b1;
    @(negedge clk); chk("R10", 3, 0, 4);
    cur_req = "R11";
    pulse_wake(); chk("R11", 3, 0, 4);
    osc = 1'b0; repeat (2) @(negedge clk); chk("R11", 3, 0, 4);
    pulse_wake(); chk("R11", 1, 1, 6);

    cur_req = "R10";
    wr(3'b101, 1'b1); arm();
    @(negedge clk); osc = 1'b1;
    @(negedge clk); osc = 1'b0; chk("R10", 3, 0, 1);
    pulse_wake(); chk("R11", 1, 1, 6);
    wr(3'b011, 1'b1); chk("R10", 1, 1, 4);

    repeat (2) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule